// File: doc/BRIEF.md
# Exposure Timer and Shutter Controller

This block runs one exposure at a time. It counts down in milliseconds and drives a shutter line. A host sets an exposure length with a strobed 24-bit argument. That value stays stored until the host writes a new one. A start strobe begins the exposure. The shutter opens only when the shutter-enable input is high at that moment. The stored time is then copied into a down counter, which loses one count on each cycle where the external one-millisecond tick is high.

While the exposure runs, the host can pause it and resume it. Pausing closes the shutter and freezes the count. Resuming reopens the shutter if it was in use and restarts the count. The remaining time is visible on an output at all times. An abort ends any phase, closes the shutter and gives a one-cycle done reply.

When the count reaches zero, the shutter closes. A settle phase then counts the programmed number of ticks and finishes with a one-cycle readout-start pulse. A zero exposure time skips the exposure and goes straight to the settle phase, with the shutter kept closed.

Top module: `exp_shutter_ctrl`

## Requirements
- R1: A set strobe stores `cmd_arg` as the exposure length in milliseconds. The value is used by every later start until another set strobe arrives, and this holds even if the set strobe arrives while an exposure is active.
- R2: A start strobe in the idle phase raises `busy` and loads `remain_ms` with the stored length on the next cycle. In that same cycle, `shutter_n` goes to 0 (open) if `shutter_en` is 1 and the length is non-zero; otherwise `shutter_n` stays 1 (closed).
- R3: While exposing, `remain_ms` drops by exactly one for each cycle with `ms_tick` high, never wraps below zero, and does not change on cycles with `ms_tick` low.
- R4: When the tick that takes `remain_ms` to zero is taken, `shutter_n` returns to 1. After that, exactly `settle_ms` further ticks are counted. On the cycle after the last of them (or the cycle after entry when `settle_ms` is 0), `readout_go` is high for one cycle and `busy` falls in that same cycle.
- R5: A pause strobe while exposing sets `shutter_n` to 1 and freezes `remain_ms`, whatever the ticks do.
- R6: A resume strobe while paused sets `shutter_n` back to 0 if the shutter was opened at start, or keeps it at 1 if not, and counting continues from the frozen value.
- R7: An abort strobe makes `done_pulse` high for exactly one cycle, in any phase. If the block is active, the abort also returns it to idle with `shutter_n` at 1 and `remain_ms` at 0, and no `readout_go` follows, including when the abort arrives during the settle phase.
- R8: A start strobe while active is ignored: `remain_ms` and `shutter_n` are unchanged.
- R9: A start with a stored length of zero never opens the shutter and enters the settle phase at once.
- R10: Pause and resume strobes in the idle or settle phase have no effect: `busy`, `shutter_n` and the `readout_go` timing are unchanged.
- R11: After reset, `shutter_n` is 1, and `remain_ms`, `busy`, `readout_go` and `done_pulse` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_set | input | 1 | Store `cmd_arg` as the exposure length |
| cmd_start | input | 1 | Begin an exposure |
| cmd_pause | input | 1 | Pause a running exposure |
| cmd_resume | input | 1 | Resume a paused exposure |
| cmd_abort | input | 1 | Abort; always answered with `done_pulse` |
| cmd_arg | input | AW (24) | Exposure length in milliseconds |
| shutter_en | input | 1 | Use the shutter for the next start |
| settle_ms | input | SW (16) | Settle ticks after close, loaded at entry to the settle phase |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| shutter_n | output | 1 | Shutter drive: 0 open, 1 closed |
| remain_ms | output | AW (24) | Milliseconds left in the exposure |
| busy | output | 1 | Exposing, paused or settling |
| readout_go | output | 1 | One-cycle readout-start request |
| done_pulse | output | 1 | One-cycle abort reply |

## Verification
Every output is a register. So `busy`, `remain_ms` and `shutter_n` respond on the first clock edge that samples a strobe or tick, and `done_pulse` does too. The `readout_go` pulse arrives one edge after the settle count has reached zero. The bench drives each strobe for exactly one cycle starting at a falling edge, and it samples at the next falling edge. That places every check half a period after the edge that caused it. It then waits one more cycle before looking for `readout_go`. A falling-edge counter of `readout_go` pulses confirms that none appear after an abort.

// File: rtl/exp_pkg.sv
package exp_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_EXPOSE = 2'd1,
    PH_PAUSE  = 2'd2,
    PH_SETTLE = 2'd3
  } phase_t;

  // shutter is opened at start only when enabled and there is time to expose
  function automatic logic opens_at_start(input logic en, input logic nonzero_len);
    return en & nonzero_len;
  endfunction

  function automatic logic phase_active(input phase_t ph);
    return ph != PH_IDLE;
  endfunction

endpackage

// File: rtl/exp_count.sv
module exp_count #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         clear,
  input  logic         dec,
  output logic [W-1:0] cnt
);

  function automatic logic [W-1:0] step_down(input logic [W-1:0] v);
    return (v == '0) ? v : v - 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= '0;
    else if (clear)  cnt <= '0;
    else if (load)   cnt <= load_val;
    else if (dec)    cnt <= step_down(cnt);
  end

  // R3: the count never wraps upward except through an explicit load
  assert_no_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !clear) |=> (cnt <= $past(cnt)));

endmodule

// File: rtl/exp_seq.sv
module exp_seq
  import exp_pkg::*;
#(
  parameter int TW = 24,
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_start,
  input  logic          cmd_pause,
  input  logic          cmd_resume,
  input  logic          cmd_abort,
  input  logic          shutter_en,
  input  logic          ms_tick,
  input  logic [TW-1:0] exp_time,
  input  logic [TW-1:0] exp_cnt,
  input  logic [SW-1:0] settle_cnt,
  output logic          exp_load,
  output logic          exp_clear,
  output logic          exp_dec,
  output logic          set_load,
  output logic          set_clear,
  output logic          set_dec,
  output phase_t        phase,
  output logic          shutter_n,
  output logic          readout_go,
  output logic          done_pulse
);

  phase_t phase_nx;
  logic   shut_used;

  // named internal events
  logic is_idle, is_exp, is_pause, is_settle;
  logic len_nonzero, exp_last, settle_zero;
  logic ev_abort, ev_start, ev_start_zero, ev_pause, ev_resume;
  logic ev_expire, ev_settle_done;

  assign is_idle     = (phase == PH_IDLE);
  assign is_exp      = (phase == PH_EXPOSE);
  assign is_pause    = (phase == PH_PAUSE);
  assign is_settle   = (phase == PH_SETTLE);
  assign len_nonzero = (exp_time != '0);
  assign exp_last    = (exp_cnt == TW'(1));
  assign settle_zero = (settle_cnt == '0);

  assign ev_abort       = cmd_abort && phase_active(phase);
  assign ev_start       = cmd_start && is_idle && !cmd_abort;
  assign ev_start_zero  = ev_start && !len_nonzero;
  assign ev_pause       = cmd_pause && is_exp && !cmd_abort;
  assign ev_resume      = cmd_resume && is_pause && !cmd_abort;
  assign ev_expire      = is_exp && ms_tick && exp_last && !cmd_abort && !cmd_pause;
  assign ev_settle_done = is_settle && settle_zero && !cmd_abort;

  assign exp_load  = ev_start;
  assign exp_clear = ev_abort;
  assign exp_dec   = is_exp && ms_tick && !cmd_pause && !cmd_abort;
  assign set_load  = ev_expire || ev_start_zero;
  assign set_clear = ev_abort;
  assign set_dec   = is_settle && ms_tick && !settle_zero && !cmd_abort;

  always_comb begin
    phase_nx = phase;
    if (ev_abort)            phase_nx = PH_IDLE;
    else if (ev_start_zero)  phase_nx = PH_SETTLE;
    else if (ev_start)       phase_nx = PH_EXPOSE;
    else if (ev_pause)       phase_nx = PH_PAUSE;
    else if (ev_resume)      phase_nx = PH_EXPOSE;
    else if (ev_expire)      phase_nx = PH_SETTLE;
    else if (ev_settle_done) phase_nx = PH_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase      <= PH_IDLE;
      shutter_n  <= 1'b1;
      shut_used  <= 1'b0;
      readout_go <= 1'b0;
      done_pulse <= 1'b0;
    end else begin
      phase      <= phase_nx;
      readout_go <= ev_settle_done;
      done_pulse <= cmd_abort;
      if (ev_start) shut_used <= opens_at_start(shutter_en, len_nonzero);
      if (ev_abort || ev_pause || ev_expire) shutter_n <= 1'b1;
      else if (ev_start)  shutter_n <= ~opens_at_start(shutter_en, len_nonzero);
      else if (ev_resume) shutter_n <= ~shut_used;
    end
  end

  // R2: the shutter is only ever open during the exposing phase
  assert_open_only_exposing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !shutter_n |-> (phase == PH_EXPOSE));

  // R4: a readout request only ever ends a settle phase
  assert_go_after_settle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    readout_go |-> ($past(phase) == PH_SETTLE && phase == PH_IDLE));

  // R5: the count stays frozen while paused
  assert_pause_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (is_pause && !cmd_resume && !cmd_abort) |=> $stable(exp_cnt));

  // R7: a done reply is only given for an abort strobe
  assert_done_from_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> $past(cmd_abort));

  // R8: a start while exposing leaves the count alone
  assert_busy_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_start && is_exp && !ms_tick && !cmd_pause && !cmd_abort) |=> $stable(exp_cnt));

  // R9: zero-length start keeps the shutter closed and enters settle
  assert_zero_start_closed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_start && is_idle && !cmd_abort && exp_time == '0) |=>
      (shutter_n && phase == PH_SETTLE));

endmodule

// File: rtl/exp_shutter_ctrl.sv
module exp_shutter_ctrl
  import exp_pkg::*;
#(
  parameter int AW = 24,
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_set,
  input  logic          cmd_start,
  input  logic          cmd_pause,
  input  logic          cmd_resume,
  input  logic          cmd_abort,
  input  logic [AW-1:0] cmd_arg,
  input  logic          shutter_en,
  input  logic [SW-1:0] settle_ms,
  input  logic          ms_tick,
  output logic          shutter_n,
  output logic [AW-1:0] remain_ms,
  output logic          busy,
  output logic          readout_go,
  output logic          done_pulse
);

  logic [AW-1:0] exp_time;
  logic [AW-1:0] exp_cnt;
  logic [SW-1:0] settle_cnt;
  logic          exp_load, exp_clear, exp_dec;
  logic          set_load, set_clear, set_dec;
  phase_t        phase;

  // R1: stored length, changed only by a set strobe
  always_ff @(posedge clk) begin
    if (!rst_n)       exp_time <= '0;
    else if (cmd_set) exp_time <= cmd_arg;
  end

  exp_count #(.W(AW)) i_exp_count (
    .clk(clk), .rst_n(rst_n),
    .load(exp_load), .load_val(exp_time), .clear(exp_clear), .dec(exp_dec),
    .cnt(exp_cnt)
  );

  exp_count #(.W(SW)) i_settle_count (
    .clk(clk), .rst_n(rst_n),
    .load(set_load), .load_val(settle_ms), .clear(set_clear), .dec(set_dec),
    .cnt(settle_cnt)
  );

  exp_seq #(.TW(AW), .SW(SW)) i_exp_seq (
    .clk(clk), .rst_n(rst_n),
    .cmd_start(cmd_start), .cmd_pause(cmd_pause), .cmd_resume(cmd_resume),
    .cmd_abort(cmd_abort), .shutter_en(shutter_en), .ms_tick(ms_tick),
    .exp_time(exp_time), .exp_cnt(exp_cnt), .settle_cnt(settle_cnt),
    .exp_load(exp_load), .exp_clear(exp_clear), .exp_dec(exp_dec),
    .set_load(set_load), .set_clear(set_clear), .set_dec(set_dec),
    .phase(phase), .shutter_n(shutter_n), .readout_go(readout_go),
    .done_pulse(done_pulse)
  );

  assign remain_ms = exp_cnt;
  assign busy      = phase_active(phase);

  // R7: after an abort of an active exposure the block is idle and closed
  assert_abort_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_abort && busy) |=> (!busy && shutter_n && remain_ms == '0));

endmodule

// File: tb/test_exp_shutter_ctrl.sv
`timescale 1ns/1ps
module test_exp_shutter_ctrl;

  localparam int AW = 24;
  localparam int SW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_set = 0, cmd_start = 0, cmd_pause = 0, cmd_resume = 0, cmd_abort = 0;
  logic [AW-1:0] cmd_arg = '0;
  logic          shutter_en = 0;
  logic [SW-1:0] settle_ms = '0;
  logic          ms_tick = 0;
  logic          shutter_n, busy, readout_go, done_pulse;
  logic [AW-1:0] remain_ms;

  int n_chk = 0;
  int n_fail = 0;
  int go_seen = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  exp_shutter_ctrl #(.AW(AW), .SW(SW)) i_exp_shutter_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_set(cmd_set), .cmd_start(cmd_start),
    .cmd_pause(cmd_pause), .cmd_resume(cmd_resume), .cmd_abort(cmd_abort),
    .cmd_arg(cmd_arg), .shutter_en(shutter_en), .settle_ms(settle_ms),
    .ms_tick(ms_tick), .shutter_n(shutter_n), .remain_ms(remain_ms),
    .busy(busy), .readout_go(readout_go), .done_pulse(done_pulse)
  );

  always @(negedge clk) if (readout_go) go_seen++;

  task automatic chk(input string req, input string what, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // 0 set, 1 start, 2 pause, 3 resume, 4 abort, 5 tick
  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: cmd_set = 1;
      1: cmd_start = 1;
      2: cmd_pause = 1;
      3: cmd_resume = 1;
      4: cmd_abort = 1;
      default: ms_tick = 1;
    endcase
    @(negedge clk);
    cmd_set = 0; cmd_start = 0; cmd_pause = 0; cmd_resume = 0; cmd_abort = 0; ms_tick = 0;
  endtask

  task automatic set_len(input int v);
    cmd_arg = AW'(v);
    pulse(0);
  endtask

  // expects the block in the settle phase with n ticks left to take
  task automatic finish_settle(input int n, input string req);
    for (int j = 0; j < n; j++) begin
      pulse(5);
      chk(req, "no go during settle", readout_go, 0);
      chk(req, "busy during settle", busy, 1);
    end
    @(negedge clk);
    chk(req, "go after settle", readout_go, 1);
    chk(req, "busy falls with go", busy, 0);
    @(negedge clk);
    chk(req, "go lasts one cycle", readout_go, 0);
  endtask

  task automatic run_expo(input int t, input int n, input bit en, input bit do_set);
    if (do_set) set_len(t);
    settle_ms = SW'(n);
    shutter_en = en;
    pulse(1);
    chk("R2", "busy on start", busy, 1);
    chk("R2", "remain loaded", remain_ms, t);
    chk((t == 0) ? "R9" : "R2", "shutter at start", shutter_n, (t > 0 && en) ? 0 : 1);
    for (int i = 0; i < t; i++) begin
      pulse(5);
      chk("R3", "remain per tick", remain_ms, t - 1 - i);
      if (i < t - 1) chk("R3", "shutter while exposing", shutter_n, en ? 0 : 1);
    end
    chk("R4", "shutter closed at zero", shutter_n, 1);
    finish_settle(n, "R4");
  endtask

  initial begin
    int g;
    repeat (3) @(negedge clk);
    chk("R11", "shutter after reset", shutter_n, 1);
    chk("R11", "remain after reset", remain_ms, 0);
    chk("R11", "busy after reset", busy, 0);
    chk("R11", "go after reset", readout_go, 0);
    chk("R11", "done after reset", done_pulse, 0);
    rst_n = 1;
    @(negedge clk);

    // sweep of lengths, settle delays and shutter enable
    for (int t = 0; t <= 4; t++)
      for (int n = 0; n <= 2; n++)
        for (int e = 0; e <= 1; e++)
          run_expo(t, n, e[0], 1'b1);

    // R3: idle cycles between ticks do not count
    set_len(3); settle_ms = 0; shutter_en = 1;
    pulse(1);
    repeat (4) @(negedge clk);
    chk("R3", "no count without tick", remain_ms, 3);
    pulse(5); pulse(5); pulse(5);
    chk("R4", "close after gaps", shutter_n, 1);
    finish_settle(0, "R4");

    // R1: stored length persists across exposures
    set_len(3);
    run_expo(3, 1, 1'b1, 1'b0);
    run_expo(3, 0, 1'b0, 1'b0);

    // R8 and R1: start while busy ignored; set while busy kept for later
    set_len(5); settle_ms = 0; shutter_en = 1;
    pulse(1); pulse(5);
    chk("R3", "remain after one tick", remain_ms, 4);
    set_len(9);
    pulse(1);
    chk("R8", "start while busy keeps remain", remain_ms, 4);
    chk("R8", "start while busy keeps shutter", shutter_n, 0);
    repeat (4) pulse(5);
    chk("R8", "old exposure expires", shutter_n, 1);
    finish_settle(0, "R8");
    pulse(1);
    chk("R1", "late set used next start", remain_ms, 9);
    pulse(4);
    @(negedge clk);

    // R5 and R6: pause and resume with shutter in use
    set_len(5); settle_ms = 0; shutter_en = 1;
    pulse(1); pulse(5); pulse(5);
    pulse(2);
    chk("R5", "pause closes shutter", shutter_n, 1);
    chk("R5", "pause keeps busy", busy, 1);
    repeat (3) pulse(5);
    chk("R5", "paused count frozen", remain_ms, 3);
    pulse(2);
    chk("R5", "second pause keeps count", remain_ms, 3);
    pulse(3);
    chk("R6", "resume reopens", shutter_n, 0);
    chk("R6", "resume keeps count", remain_ms, 3);
    pulse(5);
    chk("R6", "counting resumes", remain_ms, 2);
    pulse(5); pulse(5);
    chk("R4", "close after resumed expiry", shutter_n, 1);
    finish_settle(0, "R6");

    // R6: resume without shutter in use keeps it closed
    set_len(2); shutter_en = 0;
    pulse(1); pulse(2);
    shutter_en = 1;
    pulse(3);
    chk("R6", "resume leaves unused shutter closed", shutter_n, 1);
    pulse(5); pulse(5);
    finish_settle(0, "R6");

    // R10: pause and resume in idle
    pulse(2);
    chk("R10", "pause in idle busy", busy, 0);
    chk("R10", "pause in idle shutter", shutter_n, 1);
    pulse(3);
    chk("R10", "resume in idle busy", busy, 0);
    chk("R10", "resume in idle shutter", shutter_n, 1);

    // R10: pause and resume in settle
    set_len(1); settle_ms = 2; shutter_en = 1;
    pulse(1); pulse(5);
    pulse(2);
    chk("R10", "pause in settle shutter", shutter_n, 1);
    chk("R10", "pause in settle busy", busy, 1);
    pulse(5);
    pulse(3);
    chk("R10", "resume in settle shutter", shutter_n, 1);
    finish_settle(1, "R10");

    // R7: abort while exposing
    set_len(6); settle_ms = 0; shutter_en = 1;
    pulse(1); pulse(5);
    g = go_seen;
    pulse(4);
    chk("R7", "done on abort", done_pulse, 1);
    chk("R7", "idle after abort", busy, 0);
    chk("R7", "closed after abort", shutter_n, 1);
    chk("R7", "remain cleared", remain_ms, 0);
    @(negedge clk);
    chk("R7", "done one cycle", done_pulse, 0);
    repeat (8) pulse(5);
    chk("R7", "no go after abort", go_seen, g);

    // R7: abort during settle cancels readout
    set_len(2); settle_ms = 3;
    pulse(1); pulse(5); pulse(5); pulse(5);
    g = go_seen;
    pulse(4);
    chk("R7", "done on settle abort", done_pulse, 1);
    chk("R7", "idle after settle abort", busy, 0);
    repeat (5) pulse(5);
    chk("R7", "go cancelled", go_seen, g);

    // R7: abort in idle still replies
    pulse(4);
    chk("R7", "idle abort reply", done_pulse, 1);
    chk("R7", "idle abort stays idle", busy, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

endmodule